// File: doc/BRIEF.md
# Half-Word Write-Masked Control Register Bank

This block is a small bank of 32-bit-addressed control registers. Each register stores 16 bits. Every bus write carries its own per-bit write enables in its upper half-word: bit i+16 of the write word allows stored bit i to change. Software can therefore set or clear one field without first reading the register back. Selected fields drive control outputs of the block. These are a PHY low-power enable, a receive low-frequency-signalling enable, a two-bit lane pairing select and a full 16-bit port configuration code.

A separate helper port builds such masked write words. It takes a field description: bottom bit, top bit, a value for "off", a value for "on", and an on/off request. It returns a 32-bit word. In that word the enables cover exactly the field, and the chosen value sits at the field's bottom bit. The bus master can send this word unchanged to the field's register.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: On a write to a decoded address, each stored bit i whose enable bit wr_data[i+16] is 1 takes wr_data[i]; the new value is visible on the first clock edge after the write cycle.
- R2: On a write, each stored bit whose enable bit is 0 keeps its previous value; registers that are not addressed do not change.
- R3: rd_data returns the stored value of the register at rd_addr in bits 15:0, with bits 31:16 zero; the read is combinational, and an undecoded rd_addr reads as zero.
- R4: A synchronous active-low reset (rst_n low at a clock edge) clears every register, and so every field output, to zero.
- R5: Address decoding works as follows. Register k sits at byte address 4*k for k below NUM_REGS (default 4). Writes whose address has bits 1:0 non-zero, or whose address is 4*NUM_REGS or above, leave every register unchanged.
- R6: The field outputs map as follows. lane_pair_sel is bits 3:2 of register 0. phy_lp_en is bit 13 of register 1 and rx_lfs_en is bit 14 of register 1. port_cfg is bits 15:0 of register 2. Register 3 is read/write storage only.
- R7: The helper output fh_word[31:16] has ones exactly at bits fh_lo to fh_hi (all zero when fh_hi < fh_lo). fh_word[15:0] is (value << fh_lo) masked to those bits, where value is fh_on_val when fh_enable is 1 and fh_off_val otherwise.
- R8: A helper word for bit 13 or bit 14 of register 1, written to address 0x04, changes only that bit; the other bit keeps its value.
- R9: A full-width helper field (fh_lo 0, fh_hi 15) gives 0xFFFF0188 for on value 0x0188 and 0xFFFF1100 for off value 0x1100, and writing it to 0x08 sets port_cfg to that value.
- R10: A two-bit helper field at bits 3:2 with off value 2 and on value 3 gives 0x000C000C (on) and 0x000C0008 (off). Written to 0x00, it sets lane_pair_sel to 3 or 2 and leaves the other bits of register 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | 32 | Write word: enables in 31:16, data in 15:0 |
| rd_addr | input | ADDR_W (8) | Byte address of the read |
| rd_data | output | 32 | Read data, stored value in 15:0 |
| fh_enable | input | 1 | Helper request: 1 picks on value, 0 picks off value |
| fh_lo | input | 4 | Helper field bottom bit |
| fh_hi | input | 4 | Helper field top bit |
| fh_off_val | input | 16 | Helper value for the off request |
| fh_on_val | input | 16 | Helper value for the on request |
| fh_word | output | 32 | Masked write word built by the helper |
| phy_lp_en | output | 1 | PHY low-power enable field |
| rx_lfs_en | output | 1 | Receive low-frequency-signalling enable field |
| lane_pair_sel | output | 2 | Lane pairing select field |
| port_cfg | output | 16 | Port configuration code field |

## Verification
A wrong stored bit shows up at a field output, or in a read of that register, one cycle after the write that caused it. The bench reads back a random address and compares every field output after each write. A bad merge can let a bit change without its enable, or leak a write into a neighbouring register. The bench then sees a mismatch against its own model on the very next check, before the next write. Helper faults are pure logic, so they appear at fh_word as soon as the inputs settle.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

    localparam int HALF_W = 16;

    typedef logic [HALF_W-1:0] half_t;

    // Ones from bit lo up to bit hi inclusive; empty when hi < lo.
    function automatic half_t span_mask(input logic [3:0] lo, input logic [3:0] hi);
        half_t m;
        m = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if ((i >= int'(lo)) && (i <= int'(hi))) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/hwm_addr_dec.sv
module hwm_addr_dec #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);

    localparam int WORD_W = ADDR_W - 2;

    logic aligned;
    logic [WORD_W-1:0] word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        assign sel[k] = req && aligned && (word_idx == WORD_W'(k));
    end

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R5
    unaligned_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> (sel == '0));

endmodule

// File: rtl/hwm_field_word.sv
module hwm_field_word
    import hwm_pkg::*;
(
    input  logic        enable,
    input  logic [3:0]  lo,
    input  logic [3:0]  hi,
    input  half_t       off_val,
    input  half_t       on_val,
    output logic [31:0] word
);

    half_t mask;
    half_t chosen;
    half_t placed;

    always_comb begin
        mask   = span_mask(lo, hi);
        chosen = enable ? on_val : off_val;
        placed = half_t'(chosen << lo);
        word   = {mask, placed & mask};
    end

    // R7
    always_comb begin
        data_in_mask_chk: assert ((word[15:0] & ~word[31:16]) == 16'h0000);
    end

endmodule

// File: rtl/hwm_reg_core.sv
module hwm_reg_core
    import hwm_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REGS-1:0]             wr_sel,
    input  logic [31:0]                     wr_word,
    output logic [NUM_REGS-1:0][HALF_W-1:0] regs
);

    typedef struct packed {
        logic [NUM_REGS-1:0][HALF_W-1:0] regs;
    } core_state_t;

    core_state_t st_d, st_q;
    half_t       wr_mask;
    half_t       wr_bits;

    assign wr_mask = wr_word[31:16];
    assign wr_bits = wr_word[15:0];

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (wr_sel[k]) begin
                st_d.regs[k] = (st_q.regs[k] & ~wr_mask) | (wr_bits & wr_mask);
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.regs;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
        // R1
        masked_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_sel[k]) |->
                ((st_q.regs[k] & $past(wr_mask)) == ($past(wr_bits) & $past(wr_mask))));

        // R2
        unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.regs[k] != $past(st_q.regs[k])) |->
                ($past(wr_sel[k]) &&
                 (((st_q.regs[k] ^ $past(st_q.regs[k])) & ~$past(wr_mask)) == '0)));

        // R4
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (st_q.regs[k] == '0));
    end

endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
    import hwm_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              fh_enable,
    input  logic [3:0]        fh_lo,
    input  logic [3:0]        fh_hi,
    input  logic [15:0]       fh_off_val,
    input  logic [15:0]       fh_on_val,
    output logic [31:0]       fh_word,
    output logic              phy_lp_en,
    output logic              rx_lfs_en,
    output logic [1:0]        lane_pair_sel,
    output logic [15:0]       port_cfg
);

    localparam int PAIR_REG = 0;
    localparam int PAIR_LO  = 2;
    localparam int PWR_REG  = 1;
    localparam int PWR_BIT  = 13;
    localparam int RXS_BIT  = 14;
    localparam int CFG_REG  = 2;

    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0]             rd_sel;
    logic [NUM_REGS-1:0][HALF_W-1:0] regs;
    half_t                           rd_half;

    hwm_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_wr_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (wr_en),
        .addr  (wr_addr),
        .sel   (wr_sel)
    );

    hwm_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_rd_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (1'b1),
        .addr  (rd_addr),
        .sel   (rd_sel)
    );

    hwm_reg_core #(.NUM_REGS(NUM_REGS)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_word (wr_data),
        .regs    (regs)
    );

    hwm_field_word i_helper (
        .enable  (fh_enable),
        .lo      (fh_lo),
        .hi      (fh_hi),
        .off_val (fh_off_val),
        .on_val  (fh_on_val),
        .word    (fh_word)
    );

    always_comb begin
        rd_half = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_sel[k]) begin
                rd_half = rd_half | regs[k];
            end
        end
    end

    assign rd_data       = {16'h0000, rd_half};
    assign lane_pair_sel = regs[PAIR_REG][PAIR_LO+1:PAIR_LO];
    assign phy_lp_en     = regs[PWR_REG][PWR_BIT];
    assign rx_lfs_en     = regs[PWR_REG][RXS_BIT];
    assign port_cfg      = regs[CFG_REG];

    // R8
    pwr_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_sel[PWR_REG]) && !$past(wr_data[16+RXS_BIT])) |-> $stable(rx_lfs_en));

    // R8
    rx_keeps_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_sel[PWR_REG]) && !$past(wr_data[16+PWR_BIT])) |-> $stable(phy_lp_en));

endmodule

// File: tb/test_hwm_ctrl_bank.sv
module test_hwm_ctrl_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        fh_enable = 1'b0;
    logic [3:0]  fh_lo = '0;
    logic [3:0]  fh_hi = '0;
    logic [15:0] fh_off_val = '0;
    logic [15:0] fh_on_val = '0;
    logic [31:0] fh_word;
    logic        phy_lp_en;
    logic        rx_lfs_en;
    logic [1:0]  lane_pair_sel;
    logic [15:0] port_cfg;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    hwm_ctrl_bank i_hwm_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fh_enable(fh_enable), .fh_lo(fh_lo),
        .fh_hi(fh_hi), .fh_off_val(fh_off_val), .fh_on_val(fh_on_val), .fh_word(fh_word),
        .phy_lp_en(phy_lp_en), .rx_lfs_en(rx_lfs_en), .lane_pair_sel(lane_pair_sel),
        .port_cfg(port_cfg)
    );

    function automatic int addr_idx(input logic [7:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (int'(a[7:2]) >= NREG) return -1;
        return int'(a[7:2]);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int i;
        i = addr_idx(a);
        if (i < 0) return 32'h0;
        return {16'h0, model[i]};
    endfunction

    function automatic logic [31:0] exp_helper(input logic en, input logic [3:0] lo,
                                                input logic [3:0] hi, input logic [15:0] off_v,
                                                input logic [15:0] on_v);
        logic [15:0] m;
        logic [15:0] v;
        m = '0;
        for (int b = 0; b < 16; b++) if (b >= lo && b <= hi) m[b] = 1'b1;
        v = en ? on_v : off_v;
        v = v << lo;
        return {m, v & m};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        int i;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        i = addr_idx(a);
        if (i >= 0) model[i] = (model[i] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    task automatic check_read(input string req, input logic [7:0] a);
        rd_addr = a;
        #1;
        check(req, rd_data, exp_read(a));
    endtask

    task automatic check_fields(input string req);
        check({req, " R6 pair"}, 32'(lane_pair_sel), 32'(model[0][3:2]));
        check({req, " R6 pwr"},  32'(phy_lp_en),     32'(model[1][13]));
        check({req, " R6 rxs"},  32'(rx_lfs_en),     32'(model[1][14]));
        check({req, " R6 cfg"},  32'(port_cfg),      32'(model[2]));
    endtask

    task automatic set_helper(input logic en, input logic [3:0] lo, input logic [3:0] hi,
                              input logic [15:0] off_v, input logic [15:0] on_v);
        fh_enable = en; fh_lo = lo; fh_hi = hi; fh_off_val = off_v; fh_on_val = on_v;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NREG; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset state
        for (int k = 0; k < NREG; k++) check_read("R4 reset", 8'(4*k));
        check_fields("R4");

        // R1 / R2: partial masked writes
        do_write(8'h0C, 32'hFFFF_A5C3);
        check_read("R1 full", 8'h0C);
        do_write(8'h0C, 32'h00F0_0F0F);
        check_read("R2 partial", 8'h0C);
        check_read("R2 neighbour", 8'h08);

        // R8: adjacent one-bit fields
        set_helper(1'b1, 4'd13, 4'd13, 16'h0, 16'h1);
        check("R8 word", fh_word, 32'h2000_2000);
        do_write(8'h04, fh_word);
        set_helper(1'b1, 4'd14, 4'd14, 16'h0, 16'h1);
        do_write(8'h04, fh_word);
        check_fields("R8 both on");
        set_helper(1'b0, 4'd13, 4'd13, 16'h0, 16'h1);
        do_write(8'h04, fh_word);
        check("R8 rx kept", 32'(rx_lfs_en), 32'd1);
        check("R8 pwr off", 32'(phy_lp_en), 32'd0);

        // R9: full-width field
        set_helper(1'b1, 4'd0, 4'd15, 16'h1100, 16'h0188);
        check("R9 on word", fh_word, 32'hFFFF_0188);
        do_write(8'h08, fh_word);
        check("R9 cfg on", 32'(port_cfg), 32'h0188);
        set_helper(1'b0, 4'd0, 4'd15, 16'h1100, 16'h0188);
        check("R9 off word", fh_word, 32'hFFFF_1100);
        do_write(8'h08, fh_word);
        check("R9 cfg off", 32'(port_cfg), 32'h1100);

        // R10: two-bit field at 3:2
        do_write(8'h00, 32'hFFFF_8001);
        set_helper(1'b1, 4'd2, 4'd3, 16'h2, 16'h3);
        check("R10 on word", fh_word, 32'h000C_000C);
        do_write(8'h00, fh_word);
        check("R10 pair on", 32'(lane_pair_sel), 32'd3);
        set_helper(1'b0, 4'd2, 4'd3, 16'h2, 16'h3);
        check("R10 off word", fh_word, 32'h000C_0008);
        do_write(8'h00, fh_word);
        check("R10 pair off", 32'(lane_pair_sel), 32'd2);
        check_read("R10 rest kept", 8'h00);

        // R7: empty span and random helper patterns
        set_helper(1'b1, 4'd9, 4'd4, 16'hFFFF, 16'hFFFF);
        check("R7 empty", fh_word, 32'h0);
        for (int n = 0; n < 40; n++) begin
            logic [3:0] lo, hi;
            logic [15:0] a, b;
            logic e;
            lo = 4'($urandom); hi = 4'($urandom); a = 16'($urandom); b = 16'($urandom);
            e = 1'($urandom);
            set_helper(e, lo, hi, a, b);
            check("R7 rand", fh_word, exp_helper(e, lo, hi, a, b));
        end

        // R5: undecoded writes ignored
        do_write(8'h02, 32'hFFFF_FFFF);
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'hFD, 32'hFFFF_FFFF);
        for (int k = 0; k < NREG; k++) check_read("R5 ignored", 8'(4*k));
        check_fields("R5");
        check_read("R3 undecoded read", 8'h14);

        // R1 R2 R3 R5 R6: random traffic
        for (int n = 0; n < 300; n++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 31));
            do_write(a, $urandom);
            check_read("R3 rand", 8'($urandom_range(0, 31)));
            check_fields("R1 rand");
        end

        // R4: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NREG; k++) model[k] = '0;
        for (int k = 0; k < NREG; k++) check_read("R4 re-reset", 8'(4*k));
        check_fields("R4 again");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule